// File: doc/BRIEF.md
# Receive Packet Bridge with Message Filter

This block sits between the receive side of a PCI Express transaction-layer core and the user application. It takes packet beats (data plus start, end and valid flags), registers them at the input boundary, decides per packet whether to keep it, and presents the kept beats to the application on a valid-qualified stream after a fixed pipeline. The bridge acknowledges every packet to the core on its own, so the core never waits on the application.

Message packets are detected from the type field of the first header dword. With the compile-time parameter `DROP_MSG` at its default of 1, every beat of a message packet is discarded after being acknowledged. With `DROP_MSG` set to 0, messages travel like any other packet. The application's hold request is registered once and handed to the core without any promise of packet-accurate stalling. The core's abort and retry inputs are never used and are held low.

Top module: `rx_msg_bridge`

## Requirements
- R1: Every beat offered with `core_valid` and `core_sop` high is answered by a one-cycle `core_ack` pulse two clock edges later, whatever the application does; `core_ack` is never high otherwise.
- R2: A packet is a message when bits [28:27] of its first beat's data (bits [4:3] of the type field held in bits [28:24] of the low header dword) equal 2'b10. With `DROP_MSG` = 1, no beat of a message packet reaches the application.
- R3: With `DROP_MSG` = 0, message packets reach the application beat for beat with unchanged data, start and end flags.
- R4: `core_abort` and `core_retry` stay low at all times.
- R5: `core_hold` equals the value `app_hold` had at the previous clock edge.
- R6: A kept beat presented at clock edge k appears on the application outputs after edge k+3 (four register stages), with data, start and end flags unchanged and in arrival order.
- R7: While reset is asserted and in the first cycle after it, `app_valid` and `core_ack` are low; beats caught in the pipeline at reset are never emitted.
- R8: The keep or drop decision is taken on the start beat only and applies to every following beat up to and including the end beat; continuation beats whose data happens to match the message pattern are not classified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_data | input | DATA_W | Packet beat data from the core |
| core_sop | input | 1 | First beat of a packet |
| core_eop | input | 1 | Last beat of a packet |
| core_valid | input | 1 | Beat on the core side is valid |
| core_ack | output | 1 | Packet acknowledge pulse to the core |
| core_abort | output | 1 | Abort request to the core, held low |
| core_retry | output | 1 | Retry request to the core, held low |
| core_hold | output | 1 | Registered hold request to the core |
| app_data | output | DATA_W | Beat data to the application |
| app_sop | output | 1 | First beat of a packet to the application |
| app_eop | output | 1 | Last beat of a packet to the application |
| app_valid | output | 1 | Beat on the application side is valid |
| app_hold | input | 1 | Hold request from the application |

## Verification
The bench drives two copies of the bridge, one dropping messages and one forwarding them, with single-beat messages, multi-beat messages packed back to back against ordinary packets, and continuation beats carrying the message bit pattern; a design that re-classified each beat would then lose part of an ordinary packet or leak the tail of a message. Exact-cycle comparison of every beat catches a missing or extra pipeline stage, and exact-cycle acknowledge checking catches an acknowledge that is skipped for dropped packets or tied to the application side. A reset in the middle of a packet catches a pipeline that keeps stale valid flags and emits a fragment afterwards.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

    localparam int unsigned RXB_DATA_W = 64;
    localparam int unsigned HDR_DW_W   = 32;
    // type[4:3] of the first header dword, type field at [28:24]
    localparam int unsigned MSG_HI     = 28;
    localparam int unsigned MSG_LO     = 27;
    localparam logic [1:0]  MSG_CODE   = 2'b10;

    typedef struct packed {
        logic vld;
        logic sop;
        logic eop;
    } rxb_ctl_t;

    function automatic logic hdr_is_msg(input logic [HDR_DW_W-1:0] dw0);
        return dw0[MSG_HI:MSG_LO] == MSG_CODE;
    endfunction

endpackage

// File: rtl/rxb_reg_stage.sv
module rxb_reg_stage
    import rxb_pkg::*;
#(
    parameter int unsigned DATA_W = RXB_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rxb_ctl_t          in_ctl,
    input  logic [DATA_W-1:0] in_data,
    output rxb_ctl_t          out_ctl,
    output logic [DATA_W-1:0] out_data
);

    typedef struct packed {
        rxb_ctl_t          ctl;
        logic [DATA_W-1:0] data;
    } stage_st_t;

    stage_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.ctl.vld  = in_ctl.vld;
        // flags only meaningful on a valid beat
        st_d.ctl.sop  = in_ctl.vld && in_ctl.sop;
        st_d.ctl.eop  = in_ctl.vld && in_ctl.eop;
        st_d.data     = in_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_ctl  = st_q.ctl;
    assign out_data = st_q.data;

endmodule

// File: rtl/rxb_msg_filter.sv
module rxb_msg_filter
    import rxb_pkg::*;
#(
    parameter int unsigned DATA_W   = RXB_DATA_W,
    parameter bit          DROP_MSG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rxb_ctl_t          in_ctl,
    input  logic [DATA_W-1:0] in_data,
    output rxb_ctl_t          out_ctl,
    output logic [DATA_W-1:0] out_data,
    output logic              pkt_ack
);

    typedef struct packed {
        rxb_ctl_t          ctl;
        logic [DATA_W-1:0] data;
        logic              drop;
        logic              ack;
    } flt_st_t;

    flt_st_t st_d, st_q;
    logic    msg_hit;
    logic    head_beat;
    logic    drop_now;

    generate
        if (DROP_MSG) begin : g_drop
            assign msg_hit = hdr_is_msg(in_data[HDR_DW_W-1:0]);
        end else begin : g_keep
            assign msg_hit = 1'b0;
        end
    endgenerate

    always_comb begin
        head_beat    = in_ctl.vld && in_ctl.sop;
        // decision taken on the head beat, latched for the rest
        drop_now     = head_beat ? msg_hit : st_q.drop;
        st_d         = st_q;
        st_d.ctl.vld = in_ctl.vld && !drop_now;
        st_d.ctl.sop = in_ctl.sop && st_d.ctl.vld;
        st_d.ctl.eop = in_ctl.eop && st_d.ctl.vld;
        st_d.data    = in_data;
        st_d.ack     = head_beat;
        if (in_ctl.vld) begin
            st_d.drop = in_ctl.eop ? 1'b0 : drop_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_ctl  = st_q.ctl;
    assign out_data = st_q.data;
    assign pkt_ack  = st_q.ack;

endmodule

// File: rtl/rxb_sideband.sv
module rxb_sideband (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_in,
    output logic hold_out,
    output logic abort_out,
    output logic retry_out
);

    typedef struct packed {
        logic hold;
    } sb_st_t;

    sb_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.hold = hold_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_out  = st_q.hold;
    assign abort_out = 1'b0;
    assign retry_out = 1'b0;

endmodule

// File: rtl/rx_msg_bridge.sv
module rx_msg_bridge
    import rxb_pkg::*;
#(
    parameter int unsigned DATA_W     = RXB_DATA_W,
    parameter bit          DROP_MSG   = 1'b1,
    parameter int unsigned MID_STAGES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] core_data,
    input  logic              core_sop,
    input  logic              core_eop,
    input  logic              core_valid,
    output logic              core_ack,
    output logic              core_abort,
    output logic              core_retry,
    output logic              core_hold,
    output logic [DATA_W-1:0] app_data,
    output logic              app_sop,
    output logic              app_eop,
    output logic              app_valid,
    input  logic              app_hold
);

    rxb_ctl_t          raw_ctl;
    rxb_ctl_t          in_ctl;
    logic [DATA_W-1:0] in_data;
    rxb_ctl_t          chain_ctl  [0:MID_STAGES];
    logic [DATA_W-1:0] chain_data [0:MID_STAGES];
    rxb_ctl_t          out_ctl;

    assign raw_ctl = '{vld: core_valid, sop: core_sop, eop: core_eop};

    rxb_reg_stage #(.DATA_W(DATA_W)) u_in_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_ctl   (raw_ctl),
        .in_data  (core_data),
        .out_ctl  (in_ctl),
        .out_data (in_data)
    );

    rxb_msg_filter #(.DATA_W(DATA_W), .DROP_MSG(DROP_MSG)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_ctl   (in_ctl),
        .in_data  (in_data),
        .out_ctl  (chain_ctl[0]),
        .out_data (chain_data[0]),
        .pkt_ack  (core_ack)
    );

    generate
        for (genvar s = 0; s < MID_STAGES; s++) begin : g_mid
            rxb_reg_stage #(.DATA_W(DATA_W)) u_mid (
                .clk      (clk),
                .rst_n    (rst_n),
                .in_ctl   (chain_ctl[s]),
                .in_data  (chain_data[s]),
                .out_ctl  (chain_ctl[s+1]),
                .out_data (chain_data[s+1])
            );
        end
    endgenerate

    rxb_reg_stage #(.DATA_W(DATA_W)) u_out_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_ctl   (chain_ctl[MID_STAGES]),
        .in_data  (chain_data[MID_STAGES]),
        .out_ctl  (out_ctl),
        .out_data (app_data)
    );

    assign app_valid = out_ctl.vld;
    assign app_sop   = out_ctl.sop;
    assign app_eop   = out_ctl.eop;

    rxb_sideband u_sideband (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_in   (app_hold),
        .hold_out  (core_hold),
        .abort_out (core_abort),
        .retry_out (core_retry)
    );

endmodule

// File: rtl/rx_msg_bridge_chk.sv
module rx_msg_bridge_chk
    import rxb_pkg::*;
#(
    parameter int unsigned DATA_W     = RXB_DATA_W,
    parameter bit          DROP_MSG   = 1'b1,
    parameter int unsigned MID_STAGES = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] core_data,
    input logic              core_sop,
    input logic              core_eop,
    input logic              core_valid,
    input logic              core_ack,
    input logic              core_abort,
    input logic              core_retry,
    input logic              core_hold,
    input logic [DATA_W-1:0] app_data,
    input logic              app_sop,
    input logic              app_eop,
    input logic              app_valid,
    input logic              app_hold
);

    AST_ACK_FOLLOWS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (core_valid && core_sop) |-> ##2 core_ack);  // R1

    AST_ACK_NEEDS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        core_ack |-> $past(core_valid && core_sop, 2));  // R1

    AST_SIDEBAND_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !core_abort && !core_retry);  // R4

    AST_HOLD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> core_hold == $past(app_hold));  // R5

    AST_FLAGS_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (app_sop || app_eop) |-> app_valid);  // R6

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !app_valid && !core_ack);  // R7

    generate
        if (DROP_MSG) begin : g_drop_chk
            AST_NO_MSG_OUT: assert property (@(posedge clk) disable iff (!rst_n)
                (app_valid && app_sop) |-> !hdr_is_msg(app_data[HDR_DW_W-1:0]));  // R2
        end
        if (MID_STAGES == 1) begin : g_lat_chk
            AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
                app_valid |-> $past(core_valid, 4) && app_data == $past(core_data, 4));  // R6
        end
    endgenerate

endmodule

bind rx_msg_bridge rx_msg_bridge_chk #(
    .DATA_W     (DATA_W),
    .DROP_MSG   (DROP_MSG),
    .MID_STAGES (MID_STAGES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_data  (core_data),
    .core_sop   (core_sop),
    .core_eop   (core_eop),
    .core_valid (core_valid),
    .core_ack   (core_ack),
    .core_abort (core_abort),
    .core_retry (core_retry),
    .core_hold  (core_hold),
    .app_data   (app_data),
    .app_sop    (app_sop),
    .app_eop    (app_eop),
    .app_valid  (app_valid),
    .app_hold   (app_hold)
);

// File: tb/rx_msg_bridge_tb.sv
module rx_msg_bridge_tb;

    localparam int DW = 64;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic          rst_n = 1'b0;
    logic [DW-1:0] core_data = '0;
    logic          core_sop = 1'b0, core_eop = 1'b0, core_valid = 1'b0;
    logic          app_hold = 1'b0;

    logic          ack_a, abort_a, retry_a, hold_a, sop_a, eop_a, vld_a;
    logic [DW-1:0] data_a;
    logic          ack_b, abort_b, retry_b, hold_b, sop_b, eop_b, vld_b;
    logic [DW-1:0] data_b;

    rx_msg_bridge #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .core_data(core_data), .core_sop(core_sop),
        .core_eop(core_eop), .core_valid(core_valid), .core_ack(ack_a),
        .core_abort(abort_a), .core_retry(retry_a), .core_hold(hold_a),
        .app_data(data_a), .app_sop(sop_a), .app_eop(eop_a), .app_valid(vld_a),
        .app_hold(app_hold)
    );

    rx_msg_bridge #(.DATA_W(DW), .DROP_MSG(1'b0)) u_dut_fwd (
        .clk(clk), .rst_n(rst_n), .core_data(core_data), .core_sop(core_sop),
        .core_eop(core_eop), .core_valid(core_valid), .core_ack(ack_b),
        .core_abort(abort_b), .core_retry(retry_b), .core_hold(hold_b),
        .app_data(data_b), .app_sop(sop_b), .app_eop(eop_b), .app_valid(vld_b),
        .app_hold(app_hold)
    );

    typedef struct {
        logic [DW-1:0] data;
        logic          sop;
        logic          eop;
        int            cyc;
    } beat_t;

    beat_t q_drop[$];
    beat_t q_fwd[$];
    int    q_ack[$];
    int    cyc = 0;
    int    n_chk = 0, n_bad = 0;
    int    seen_a = 0, seen_b = 0;
    bit    done = 1'b0;
    logic  hold_prev = 1'b0;
    logic  rst_prev = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        beat_t e;
        if (rst_n) begin
            if (vld_a) begin
                seen_a++;
                if (q_drop.size() == 0) chk(1'b0, "R2 unexpected beat on dropping copy", data_a, '0);
                else begin
                    e = q_drop.pop_front();
                    chk(data_a == e.data, "R2/R6 data on dropping copy", data_a, e.data);
                    chk(cyc == e.cyc + 4, "R6 latency on dropping copy", DW'(cyc), DW'(e.cyc + 4));
                    chk({sop_a, eop_a} == {e.sop, e.eop}, "R8 flags on dropping copy",
                        DW'({sop_a, eop_a}), DW'({e.sop, e.eop}));
                end
            end
            if (vld_b) begin
                seen_b++;
                if (q_fwd.size() == 0) chk(1'b0, "R3 unexpected beat on forwarding copy", data_b, '0);
                else begin
                    e = q_fwd.pop_front();
                    chk(data_b == e.data, "R3 data on forwarding copy", data_b, e.data);
                    chk(cyc == e.cyc + 4, "R6 latency on forwarding copy", DW'(cyc), DW'(e.cyc + 4));
                    chk({sop_b, eop_b} == {e.sop, e.eop}, "R3 flags on forwarding copy",
                        DW'({sop_b, eop_b}), DW'({e.sop, e.eop}));
                end
            end
            if (ack_a) begin
                if (q_ack.size() == 0) chk(1'b0, "R1 acknowledge without head beat", DW'(cyc), '0);
                else begin
                    int c;
                    c = q_ack.pop_front();
                    chk(cyc == c + 2, "R1 acknowledge timing", DW'(cyc), DW'(c + 2));
                end
            end
            chk(ack_b == ack_a, "R1 acknowledge same for both copies", DW'(ack_b), DW'(ack_a));
            chk(!abort_a && !retry_a && !abort_b && !retry_b, "R4 abort/retry low",
                DW'({abort_a, retry_a, abort_b, retry_b}), '0);
            if (rst_prev)
                chk(hold_a == hold_prev && hold_b == hold_prev, "R5 hold pass-through",
                    DW'({hold_a, hold_b}), DW'({hold_prev, hold_prev}));
        end
        hold_prev = app_hold;
        rst_prev  = rst_n;
    end

    task automatic send_pkt(input int nb, input logic [4:0] ty, input logic [DW-1:0] seed,
                            input bit cont_msg, input bit gap);
        bit is_msg;
        is_msg = (ty[4:3] == 2'b10);
        for (int b = 0; b < nb; b++) begin
            beat_t e;
            logic [DW-1:0] d;
            @(negedge clk);
            d = seed ^ DW'(b * 32'h0101_0101);
            if (b == 0) d[28:24] = ty;
            else        d[28:27] = cont_msg ? 2'b10 : 2'b01;
            core_data  = d;
            core_valid = 1'b1;
            core_sop   = (b == 0);
            core_eop   = (b == nb - 1);
            app_hold   = d[5];
            e.data = d; e.sop = (b == 0); e.eop = (b == nb - 1); e.cyc = cyc;
            q_fwd.push_back(e);
            if (!is_msg) q_drop.push_back(e);
            if (b == 0) q_ack.push_back(cyc);
        end
        if (gap) idle(1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            core_valid = 1'b0; core_sop = 1'b0; core_eop = 1'b0;
        end
    endtask

    task automatic drain_check(input string tag);
        idle(8);
        chk(q_drop.size() == 0, {tag, " R2 dropping copy drained"}, DW'(q_drop.size()), '0);
        chk(q_fwd.size() == 0, {tag, " R3 forwarding copy drained"}, DW'(q_fwd.size()), '0);
        chk(q_ack.size() == 0, {tag, " R1 all heads acknowledged"}, DW'(q_ack.size()), '0);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        int sa, sb;
        // R7: reset state
        repeat (3) @(negedge clk);
        chk(!vld_a && !vld_b && !ack_a && !ack_b, "R7 outputs low in reset",
            DW'({vld_a, vld_b, ack_a, ack_b}), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!vld_a && !ack_a, "R7 outputs low after release", DW'({vld_a, ack_a}), '0);

        // ordinary write, 3 beats with gap
        send_pkt(3, 5'b00000, 64'h1111_2222_0000_3333, 1'b0, 1'b1);
        // single-beat message (type 10100)
        send_pkt(1, 5'b10100, 64'hAAAA_0000_0000_0001, 1'b0, 1'b0);
        // 4-beat message back to back with next packet (R2, R8)
        send_pkt(4, 5'b10000, 64'hBBBB_0000_0000_0010, 1'b0, 1'b0);
        // completion whose continuation beats carry the message pattern (R8)
        send_pkt(3, 5'b01010, 64'hCCCC_0000_0000_0020, 1'b1, 1'b0);
        // type 11000 is not a message (R2)
        send_pkt(2, 5'b11000, 64'hDDDD_0000_0000_0030, 1'b0, 1'b0);
        // message immediately followed by a single-beat ordinary packet
        send_pkt(2, 5'b10010, 64'hEEEE_0000_0000_0040, 1'b1, 1'b0);
        send_pkt(1, 5'b00100, 64'hFFFF_0000_0000_0050, 1'b0, 1'b1);
        drain_check("traffic");

        // R7: reset in the middle of a packet
        sa = seen_a; sb = seen_b;
        send_pkt(3, 5'b00000, 64'h7777_0000_0000_0060, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        core_valid = 1'b0; core_sop = 1'b0; core_eop = 1'b0;
        q_drop.delete(); q_fwd.delete();
        repeat (2) @(negedge clk);
        chk(!vld_a && !vld_b && !ack_a, "R7 outputs low during mid-packet reset",
            DW'({vld_a, vld_b, ack_a}), '0);
        rst_n = 1'b1;
        idle(8);
        chk(seen_a == sa && seen_b == sb, "R7 no fragment after reset",
            DW'(seen_a - sa + seen_b - sb), '0);

        // traffic after reset
        send_pkt(2, 5'b10110, 64'h5555_0000_0000_0070, 1'b0, 1'b0);
        send_pkt(4, 5'b00001, 64'h6666_0000_0000_0080, 1'b1, 1'b1);
        drain_check("after reset");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule